// File: doc/BRIEF.md
# Shifter with condition flags

A single-cycle word shifter for an integer execution pipe. Each strobed operation shifts a data word left logically, right logically or right arithmetically. The shift amount comes either from a small immediate field or from the low bits of a register operand. The block returns the shifted word together with the next values of the carry, overflow, sign and zero condition flags. The saturation flag is not touched by shifts, so its incoming value is handed straight back.

Results and flags are captured on the clock edge that follows a valid strobe, and a one-cycle `done` pulse marks them. While no operation is issued, every output holds its last value. The caller can therefore read the flag word at leisure.

Top module: `shift_flag_unit`

## Requirements
- R1: With `op` = 2'b00 (logical left), `result` equals `data_in` shifted left by the count, with zeros entering at bit 0.
- R2: With `op` = 2'b01 (logical right), `result` equals `data_in` shifted right by the count, with zeros entering at the top bit.
- R3: With `op` = 2'b10 (arithmetic right), the vacated upper bits are copies of the top bit of `data_in` (0x80000000 by 1 gives 0xC0000000).
- R4: For a non-zero count n, `cy` is the final bit pushed out of the word: `data_in[W-n]` for a left shift and `data_in[n-1]` for a right shift.
- R5: For a zero count, `result` equals `data_in` and `cy` is 0.
- R6: `ov` is 0 after every executed shift.
- R7: `z` is 1 exactly when `result` is zero, and `s` equals the top bit of `result`.
- R8: When `use_imm` is 1, the count is `imm_cnt`. Otherwise the count is the low log2(W) bits of `reg_cnt`, and its upper bits have no effect.
- R9: `sat` takes the value of `sat_in` on each executed shift.
- R10: When `in_valid` is 0, or when `op` = 2'b11, no operation executes. In that cycle all of `result`, `cy`, `ov`, `s`, `z` and `sat` keep their values, and `done` is 0 on the following cycle.
- R11: After reset, every output is 0.
- R12: Results and flags of an operation strobed in cycle t appear after the clock edge ending cycle t, and `done` is 1 for that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 2 | 00 left logical, 01 right logical, 10 right arithmetic, 11 no operation |
| use_imm | input | 1 | 1 selects the immediate count |
| imm_cnt | input | 5 | Immediate shift count |
| reg_cnt | input | 32 | Register count operand; only the low 5 bits are used |
| data_in | input | 32 | Word to shift |
| sat_in | input | 1 | Current saturation flag |
| result | output | 32 | Shifted word |
| cy | output | 1 | Carry flag |
| ov | output | 1 | Overflow flag |
| s | output | 1 | Sign flag |
| z | output | 1 | Zero flag |
| sat | output | 1 | Saturation flag, passed through |
| done | output | 1 | One-cycle pulse when outputs were updated |

## Verification
Carry capture and zero detection fall together whenever a shift pushes the only set bit out of the word. A case is 0x8 shifted right by 4, or 0x80000000 shifted left by 1: `cy` and `z` must then both be 1. The sweep runs every count against patterns with isolated set bits, and compares both flags against arithmetic expectations for each vector. The zero-count carry override is met in the same sweep, with the all-ones pattern, where a stale carry would be visible at once.

// File: rtl/shift_flag_unit.sv
module shift_flag_unit #(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0]           op,
  input  logic                 use_imm,
  input  logic [$clog2(W)-1:0] imm_cnt,
  input  logic [W-1:0]         reg_cnt,
  input  logic [W-1:0]         data_in,
  input  logic                 sat_in,
  output logic [W-1:0]         result,
  output logic                 cy,
  output logic                 ov,
  output logic                 s,
  output logic                 z,
  output logic                 sat,
  output logic                 done
);
  localparam int SW = $clog2(W);
  localparam logic [1:0] OP_SHL = 2'b00;
  localparam logic [1:0] OP_SAR = 2'b10;
  localparam logic [1:0] OP_NOP = 2'b11;

  function automatic logic [W-1:0] flip(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  logic [SW-1:0] amt;
  logic          go, left, fill;
  logic [W-1:0]  src, shifted;
  logic [W:0]    stg [0:SW];

  assign amt    = use_imm ? imm_cnt : reg_cnt[SW-1:0];
  assign go     = in_valid && (op != OP_NOP);
  assign left   = (op == OP_SHL);
  assign fill   = (op == OP_SAR) & data_in[W-1];
  assign src    = left ? flip(data_in) : data_in;
  assign stg[0] = {src, 1'b0};

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int D = 1 << k;
    assign stg[k+1] = amt[k] ? {{D{fill}}, stg[k][W:D]} : stg[k];
  end

  assign shifted = left ? flip(stg[SW][W:1]) : stg[SW][W:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      cy     <= 1'b0;
      ov     <= 1'b0;
      s      <= 1'b0;
      z      <= 1'b0;
      sat    <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= go;
      if (go) begin
        result <= shifted;
        cy     <= stg[SW][0];
        ov     <= 1'b0;
        s      <= shifted[W-1];
        z      <= (shifted == '0);
        sat    <= sat_in;
      end
    end
  end

  a_r5_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    go && amt == '0 |=> result == $past(data_in) && !cy);
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !ov);
  a_r7_z_and_s: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (z == (result == '0)) && (s == result[W-1]));
  a_r9_sat_pass: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> sat == $past(sat_in));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(result) && $stable(cy) && $stable(sat) && $stable(z) && !done);
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> done);
endmodule

// File: tb/shift_flag_unit_tb.sv
module shift_flag_unit_tb;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op = 2'b00;
  logic        use_imm = 1'b0;
  logic [4:0]  imm_cnt = '0;
  logic [31:0] reg_cnt = '0;
  logic [31:0] data_in = '0;
  logic        sat_in = 1'b0;
  logic [31:0] result;
  logic        cy, ov, s, z, sat, done;

  int n_tests = 0;
  int n_fail  = 0;

  shift_flag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .use_imm(use_imm),
    .imm_cnt(imm_cnt), .reg_cnt(reg_cnt), .data_in(data_in), .sat_in(sat_in),
    .result(result), .cy(cy), .ov(ov), .s(s), .z(z), .sat(sat), .done(done)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] o, input logic [31:0] d, input int n,
                       input logic imm, input logic [26:0] upper, input logic sv);
    @(negedge clk);
    op = o; data_in = d; sat_in = sv; use_imm = imm;
    imm_cnt = imm ? 5'(n) : 5'(~n);
    reg_cnt = imm ? ~{upper, 5'(n)} : {upper, 5'(n)};
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_one(input logic [1:0] o, input logic [31:0] d, input int n,
                         input logic imm, input logic [26:0] upper, input logic sv);
    logic [31:0] e;
    logic ec;
    issue(o, d, n, imm, upper, sv);
    case (o)
      2'b00: e = d << n;
      2'b01: e = d >> n;
      default: e = 32'($signed(d) >>> n);
    endcase
    if (n == 0) ec = 1'b0;
    else if (o == 2'b00) ec = d[32-n];
    else ec = d[n-1];
    chk(o == 2'b00 ? "R1 left result" : (o == 2'b01 ? "R2 right result" : "R3 arith result"), result, e);
    chk(n == 0 ? "R5 zero-count carry" : "R4 carry", 32'(cy), 32'(ec));
    chk("R6 ov", 32'(ov), 32'd0);
    chk("R7 z", 32'(z), 32'(e == 0));
    chk("R7 s", 32'(s), 32'(e[31]));
    chk("R9 sat", 32'(sat), 32'(sv));
    chk("R12 done", 32'(done), 32'd1);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] pats [8];
    logic [31:0] keep;
    pats = '{32'h0, 32'h1, 32'h8, 32'h80000000, 32'h40000000,
             32'hFFFFFFFF, 32'h4000000F, 32'h12345678};
    repeat (3) @(negedge clk);
    chk("R11 reset result", result, 32'd0);
    chk("R11 reset flags", {26'd0, cy, ov, s, z, sat, done}, 32'd0);
    rst_n = 1'b1;

    for (int p = 0; p < 8; p++)
      for (int o = 0; o < 3; o++)
        for (int n = 0; n < 32; n++)
          run_one(2'(o), pats[p], n, 1'((n + p) % 2), 27'(p * 7919 + n + 1), 1'((n + o) % 2));

    // Specific boundary cases
    run_one(2'b10, 32'h80000000, 1, 1'b0, 27'h5, 1'b0);
    chk("R3 sign fill", result, 32'hC0000000);
    run_one(2'b01, 32'h8, 4, 1'b1, 27'h0, 1'b1);
    chk("R4 carry with zero result", {30'd0, cy, z}, 32'd3);
    run_one(2'b00, 32'h80000000, 1, 1'b0, 27'h1, 1'b0);
    chk("R4 left carry with zero result", {30'd0, cy, z}, 32'd3);

    // R8: upper register bits ignored (count 33 acts as 1)
    @(negedge clk);
    op = 2'b01; data_in = 32'h40; use_imm = 1'b0; reg_cnt = 32'h21; imm_cnt = 5'd7;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 register count low bits", result, 32'h20);

    // R10: no strobe and reserved op keep state
    keep = result;
    @(negedge clk);
    data_in = 32'hDEADBEEF; op = 2'b00; sat_in = 1'b1; use_imm = 1'b1; imm_cnt = 5'd3;
    @(negedge clk);
    chk("R10 idle result", result, keep);
    chk("R10 idle done", 32'(done), 32'd0);
    chk("R10 idle flags", {28'd0, cy, s, z, sat}, {28'd0, 1'b0, keep[31], keep == 0, 1'b0});
    op = 2'b11; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 reserved op result", result, keep);
    chk("R10 reserved op done", 32'(done), 32'd0);
    chk("R10 reserved op sat", 32'(sat), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule